// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs one atomic memory operation at a time against a single-port memory with a 64-bit data path. A request carries a 5-bit function code, a size code (32-bit or 64-bit), a word address and a 64-bit source operand. The unit reads the addressed location and forms the new value from the old value and the source. It writes the new value back and returns the old value for the destination register.

Arithmetic, logical, swap, and signed and unsigned min/max operations are supported. A load-reserved / store-conditional pair shares one reservation register, which covers one 8-byte granule. The unit also watches an external store port, so that plain stores made elsewhere can break a reservation.

Addresses are 32-bit word addresses. Bit 0 selects the upper (1) or lower (0) half of the 64-bit memory line, and the remaining bits form the line (granule) index. Memory reads have one cycle of latency.

Top module: `amo_unit`

## Requirements
- R1: Function codes 0x00, 0x01, 0x04, 0x08 and 0x0C store old+src, src, old^src, old|src and old&src respectively.
- R2: Codes 0x10 and 0x14 perform signed min and max, and codes 0x18 and 0x1C perform unsigned min and max. The source is written only when it is strictly less (min) or strictly greater (max) than the old value. On a tie, or when the comparison fails, memory is not written.
- R3: Size code 3 operates on the full 64-bit line. Size code 2 operates on the 32-bit half chosen by address bit 0. Only that half is written, and bits 63:32 of the source are ignored.
- R4: result_o carries the value memory held before the operation. For 32-bit operations that value is sign-extended from bit 31.
- R5: A request is accepted in a cycle where busy_o is low. The read is issued in the next cycle. done_o pulses for exactly one cycle, two cycles after the read, and any memory write is issued in that same cycle. busy_o stays high from the read cycle through the done cycle.
- R6: A request presented while busy_o is high is ignored.
- R7: Load-reserved (code 0x02) returns the old value, writes nothing, and sets the reservation to the addressed granule.
- R8: Store-conditional (code 0x03) writes the source and returns 0 if the reservation is valid for the addressed granule. Otherwise it writes nothing and returns 1. In both cases it clears the reservation.
- R9: An atomic operation, or a pulse on ext_wr_valid_i, that targets the reserved granule clears the reservation. Stores to other granules leave it intact.
- R10: After reset the unit is idle and issues no memory request. The reservation is invalid, so a first store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_func_i | input | 5 | Operation code |
| req_size_i | input | 2 | 2 = 32-bit, 3 = 64-bit |
| req_addr_i | input | AW | Word address; bit 0 selects the half |
| req_src_i | input | 64 | Source operand |
| ext_wr_valid_i | input | 1 | An external store is occurring |
| ext_wr_addr_i | input | AW-1 | Granule index of the external store |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Destination value, valid with done_o |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | AW-1 | Line index |
| mem_wmask_o | output | 2 | Half enables: bit 0 = low, bit 1 = high |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, one cycle after the read |

## Verification
The hardest states to reach are the ones where a live reservation is lost through a side path. These include an external store that hits the reserved granule, and an ordinary atomic operation on the other half of the same line. Another is a retry of a store-conditional after an earlier one has already consumed the reservation. The bench builds each of these states from a load-reserved followed by a single disturbing event. It then shows the outcome through the next store-conditional's return code and the memory line. A request held high into the busy window checks that a second operation cannot slip in.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned XLEN = 64;

  localparam logic [4:0] FN_ADD  = 5'h00;
  localparam logic [4:0] FN_SWAP = 5'h01;
  localparam logic [4:0] FN_LR   = 5'h02;
  localparam logic [4:0] FN_SC   = 5'h03;
  localparam logic [4:0] FN_XOR  = 5'h04;
  localparam logic [4:0] FN_OR   = 5'h08;
  localparam logic [4:0] FN_AND  = 5'h0C;
  localparam logic [4:0] FN_MIN  = 5'h10;
  localparam logic [4:0] FN_MAX  = 5'h14;
  localparam logic [4:0] FN_MINU = 5'h18;
  localparam logic [4:0] FN_MAXU = 5'h1C;

  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CALC, ST_WR} amo_st_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [4:0]   func_i,
  input  logic         wide_i,
  input  logic [W-1:0] old_i,   // already sign-extended for 32-bit
  input  logic [W-1:0] src_i,
  output logic [W-1:0] new_o,
  output logic         wr_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] b_s, a_u, b_u;
  logic lt_s, gt_s, lt_u, gt_u;

  always_comb begin
    b_s = wide_i ? src_i : {{HW{src_i[HW-1]}}, src_i[HW-1:0]};
    a_u = wide_i ? old_i : {{HW{1'b0}}, old_i[HW-1:0]};
    b_u = wide_i ? src_i : {{HW{1'b0}}, src_i[HW-1:0]};
    lt_s = $signed(b_s) < $signed(old_i);
    gt_s = $signed(b_s) > $signed(old_i);
    lt_u = b_u < a_u;
    gt_u = b_u > a_u;
  end

  always_comb begin
    new_o = b_s;
    wr_o  = 1'b1;
    unique case (func_i)
      FN_ADD:  new_o = old_i + b_s;
      FN_SWAP: new_o = b_s;
      FN_XOR:  new_o = old_i ^ b_s;
      FN_OR:   new_o = old_i | b_s;
      FN_AND:  new_o = old_i & b_s;
      FN_MIN:  wr_o  = lt_s;
      FN_MAX:  wr_o  = gt_s;
      FN_MINU: wr_o  = lt_u;
      FN_MAXU: wr_o  = gt_u;
      default: begin
        new_o = old_i;
        wr_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int unsigned GW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lr_i,
  input  logic          sc_i,
  input  logic          amo_i,
  input  logic [GW-1:0] addr_i,
  input  logic          ext_wr_i,
  input  logic [GW-1:0] ext_addr_i,
  output logic          match_o
);
  logic          valid_q;
  logic [GW-1:0] addr_q;
  logic          clr;

  assign match_o = valid_q && (addr_q == addr_i);
  assign clr = sc_i || (amo_i && match_o) || (ext_wr_i && ext_addr_i == addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (lr_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
    end else if (clr) begin
      valid_q <= 1'b0;
    end
  end

  // R8
  sc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_i |=> !valid_q);
  // R9
  ext_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_wr_i && valid_q && ext_addr_i == addr_q && !lr_i) |=> !valid_q);
  // R7
  lr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_i |=> (valid_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [4:0]      req_func_i,
  input  logic [1:0]      req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [XLEN-1:0] req_src_i,
  input  logic            ext_wr_valid_i,
  input  logic [AW-2:0]   ext_wr_addr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-2:0]   mem_addr_o,
  output logic [1:0]      mem_wmask_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i
);
  localparam int unsigned GW = AW - 1;
  localparam int unsigned HW = XLEN / 2;

  amo_st_e         st_q;
  logic [4:0]      func_q;
  logic            wide_q;
  logic [AW-1:0]   addr_q;
  logic [XLEN-1:0] src_q;
  logic [XLEN-1:0] res_q;
  logic [XLEN-1:0] wdata_q;
  logic            upd_q;

  logic [HW-1:0]   old_half;
  logic [XLEN-1:0] old_ext;
  logic [XLEN-1:0] alu_new, wr_val;
  logic            alu_wr, resv_match;
  logic            is_lr, is_sc;

  assign is_lr = (func_q == FN_LR);
  assign is_sc = (func_q == FN_SC);

  always_comb begin
    old_half = addr_q[0] ? mem_rdata_i[XLEN-1:HW] : mem_rdata_i[HW-1:0];
    old_ext  = wide_q ? mem_rdata_i : {{HW{old_half[HW-1]}}, old_half};
  end

  amo_alu #(.W(XLEN)) u_alu (
    .func_i (func_q),
    .wide_i (wide_q),
    .old_i  (old_ext),
    .src_i  (src_q),
    .new_o  (alu_new),
    .wr_o   (alu_wr)
  );

  amo_resv #(.GW(GW)) u_resv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lr_i       (done_o && is_lr),
    .sc_i       (done_o && is_sc),
    .amo_i      (done_o && !is_lr && !is_sc),
    .addr_i     (addr_q[AW-1:1]),
    .ext_wr_i   (ext_wr_valid_i),
    .ext_addr_i (ext_wr_addr_i),
    .match_o    (resv_match)
  );

  assign wr_val = is_sc ? src_q : alu_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      func_q  <= '0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      res_q   <= '0;
      wdata_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          func_q <= req_func_i;
          wide_q <= (req_size_i == SZ_DWORD);
          addr_q <= req_addr_i;
          src_q  <= req_src_i;
          st_q   <= ST_RD;
        end
        ST_RD: st_q <= ST_CALC;
        ST_CALC: begin
          res_q   <= is_sc ? {{(XLEN-1){1'b0}}, !resv_match} : old_ext;
          upd_q   <= is_sc ? resv_match : (!is_lr && alu_wr);
          wdata_q <= wide_q ? wr_val : {wr_val[HW-1:0], wr_val[HW-1:0]};
          st_q    <= ST_WR;
        end
        ST_WR: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_WR);
  assign result_o    = res_q;
  assign mem_req_o   = (st_q == ST_RD) || (done_o && upd_q);
  assign mem_we_o    = done_o && upd_q;
  assign mem_addr_o  = addr_q[AW-1:1];
  assign mem_wmask_o = wide_q ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);
  assign mem_wdata_o = wdata_q;

  // R5
  rd_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> (mem_req_o && !mem_we_o && busy_o));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  wr_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (done_o && mem_req_o));
  // R8
  sc_fail_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_sc && result_o[0]) |-> !mem_we_o);
  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(addr_q) && $stable(func_q)));
endmodule

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  import amo_pkg::*;
  localparam int AW = 7;
  localparam int GW = AW - 1;
  localparam int NV = 14;

  typedef struct packed {
    logic [4:0]  f;
    logic [1:0]  sz;
    logic [6:0]  addr;
    logic [63:0] src;
    logic [63:0] init;
    logic [63:0] eres;
    logic [63:0] emem;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'h00, 2'd3, 7'd2,  64'h3, 64'h5, 64'h5, 64'h8},
    '{5'h00, 2'd2, 7'd4,  64'h1, 64'h11111111_7FFFFFFF, 64'h00000000_7FFFFFFF, 64'h11111111_80000000},
    '{5'h01, 2'd2, 7'd7,  64'h5, 64'h80000001_22222222, 64'hFFFFFFFF_80000001, 64'h00000005_22222222},
    '{5'h04, 2'd3, 7'd8,  64'hFF00, 64'hF0F0, 64'hF0F0, 64'h0FF0},
    '{5'h08, 2'd3, 7'd10, 64'h1010, 64'h0101, 64'h0101, 64'h1111},
    '{5'h0C, 2'd3, 7'd12, 64'h0FF0, 64'hFF0F, 64'hFF0F, 64'h0F00},
    '{5'h10, 2'd3, 7'd14, 64'hFFFFFFFF_FFFFFFFF, 64'h5, 64'h5, 64'hFFFFFFFF_FFFFFFFF},
    '{5'h18, 2'd3, 7'd16, 64'hFFFFFFFF_FFFFFFFF, 64'h5, 64'h5, 64'h5},
    '{5'h14, 2'd2, 7'd18, 64'h3, 64'hAAAAAAAA_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFE, 64'hAAAAAAAA_00000003},
    '{5'h1C, 2'd2, 7'd20, 64'h3, 64'h00000000_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFE, 64'h00000000_FFFFFFFE},
    '{5'h10, 2'd2, 7'd22, 64'h12345678_80000000, 64'h3, 64'h3, 64'h00000000_80000000},
    '{5'h14, 2'd3, 7'd24, 64'h7, 64'h7, 64'h7, 64'h7},
    '{5'h03, 2'd3, 7'd26, 64'h42, 64'h99, 64'h1, 64'h99},
    '{5'h1C, 2'd3, 7'd28, 64'h80000000_00000000, 64'h7FFFFFFF_FFFFFFFF, 64'h7FFFFFFF_FFFFFFFF, 64'h80000000_00000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_func = '0;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_src = '0;
  logic ext_valid = 1'b0;
  logic [GW-1:0] ext_addr = '0;
  logic busy, done, mem_req, mem_we;
  logic [63:0] result, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [GW-1:0] mem_addr;
  logic [1:0] mem_wmask;

  logic [63:0] mem [64];
  logic pre_we = 1'b0;
  logic [GW-1:0] pre_idx = '0;
  logic [63:0] pre_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  amo_unit #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_func_i(req_func), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_src_i(req_src),
    .ext_wr_valid_i(ext_valid), .ext_wr_addr_i(ext_addr),
    .busy_o(busy), .done_o(done), .result_o(result),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wmask_o(mem_wmask), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (pre_we) mem[pre_idx] <= pre_data;
    else if (mem_req && mem_we) begin
      if (mem_wmask[0]) mem[mem_addr][31:0]  <= mem_wdata[31:0];
      if (mem_wmask[1]) mem[mem_addr][63:32] <= mem_wdata[63:32];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [GW-1:0] idx, input logic [63:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = idx; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic wait_done(output logic [63:0] res);
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R5 timeout waiting for done actual=0 expected=1");
    end
    res = result;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [4:0] f, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [63:0] s,
                        output logic [63:0] res);
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_size = sz; req_addr = a; req_src = s;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(res);
  endtask

  task automatic ext_store(input logic [GW-1:0] g);
    @(negedge clk);
    ext_valid = 1'b1; ext_addr = g;
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    // R10: idle, no memory traffic
    chk("R10 busy", {63'b0, busy}, 64'h0);
    chk("R10 done", {63'b0, done}, 64'h0);
    chk("R10 mem_req", {63'b0, mem_req}, 64'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R4; entry 12 is a first SC after reset (R10, R8)
    for (int i = 0; i < NV; i++) begin
      preload(VECS[i].addr[AW-1:1], VECS[i].init);
      run_op(VECS[i].f, VECS[i].sz, VECS[i].addr, VECS[i].src, r);
      chk($sformatf("R1/R2/R3/R4 vec%0d result", i), r, VECS[i].eres);
      chk($sformatf("R1/R2/R3 vec%0d memory", i), mem[VECS[i].addr[AW-1:1]], VECS[i].emem);
    end

    // R5 R6: sequence timing and request during busy
    preload(6'd25, 64'd10);
    preload(6'd26, 64'd20);
    @(negedge clk);
    req_valid = 1'b1; req_func = FN_ADD; req_size = SZ_DWORD; req_addr = 7'd50; req_src = 64'd1;
    @(negedge clk);
    chk("R5 busy after accept", {63'b0, busy}, 64'h1);
    chk("R5 read issued", {62'b0, mem_req, mem_we}, 64'h2);
    req_func = FN_SWAP; req_addr = 7'd52; req_src = 64'd99;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 no done yet", {63'b0, done}, 64'h0);
    @(negedge clk);
    chk("R5 done cycle", {63'b0, done}, 64'h1);
    chk("R5 write in done cycle", {62'b0, mem_req, mem_we}, 64'h3);
    r = result;
    @(negedge clk);
    chk("R5 idle after done", {62'b0, busy, done}, 64'h0);
    chk("R5 add result", r, 64'd10);
    chk("R5 add memory", mem[25], 64'd11);
    repeat (4) @(negedge clk);
    chk("R6 ignored request left memory", mem[26], 64'd20);
    chk("R6 no activity", {63'b0, busy}, 64'h0);

    // R7 R8: reserve then conditional store succeeds once
    preload(6'd20, 64'hABCD);
    run_op(FN_LR, SZ_DWORD, 7'd40, 64'h0, r);
    chk("R7 lr result", r, 64'hABCD);
    chk("R7 lr no write", mem[20], 64'hABCD);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h77, r);
    chk("R8 sc success code", r, 64'h0);
    chk("R8 sc success memory", mem[20], 64'h77);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h88, r);
    chk("R8 sc retry fails", r, 64'h1);
    chk("R8 sc retry no write", mem[20], 64'h77);

    // R8: wrong granule fails and consumes the reservation
    preload(6'd21, 64'h5);
    run_op(FN_LR, SZ_DWORD, 7'd40, 64'h0, r);
    run_op(FN_SC, SZ_DWORD, 7'd42, 64'h6, r);
    chk("R8 sc other granule code", r, 64'h1);
    chk("R8 sc other granule memory", mem[21], 64'h5);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h9, r);
    chk("R8 sc after failed sc", r, 64'h1);
    chk("R8 memory untouched", mem[20], 64'h77);

    // R9: external store to reserved granule
    run_op(FN_LR, SZ_DWORD, 7'd40, 64'h0, r);
    ext_store(6'd20);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h1, r);
    chk("R9 ext store same granule breaks", r, 64'h1);

    // R9: external store elsewhere keeps it
    run_op(FN_LR, SZ_DWORD, 7'd40, 64'h0, r);
    ext_store(6'd21);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h55, r);
    chk("R9 ext store other granule keeps", r, 64'h0);
    chk("R9 sc memory", mem[20], 64'h55);

    // R9: AMO to other half of reserved line
    run_op(FN_LR, SZ_DWORD, 7'd40, 64'h0, r);
    run_op(FN_ADD, SZ_WORD, 7'd41, 64'h1, r);
    chk("R9 amo high half result", r, 64'h0);
    chk("R9 amo high half memory", mem[20], 64'h00000001_00000055);
    run_op(FN_SC, SZ_DWORD, 7'd40, 64'h3, r);
    chk("R9 amo same granule breaks", r, 64'h1);

    // R4 R3 R7 R8: 32-bit reserve on upper half, store into lower half
    preload(6'd22, 64'hFFFFFFF0_00000001);
    run_op(FN_LR, SZ_WORD, 7'd45, 64'h0, r);
    chk("R4 lr word sign extension", r, 64'hFFFFFFFF_FFFFFFF0);
    run_op(FN_SC, SZ_WORD, 7'd44, 64'h12345678_0000ABCD, r);
    chk("R8 sc word success", r, 64'h0);
    chk("R3 sc word lane only", mem[22], 64'hFFFFFFF0_0000ABCD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule